// File: doc/BRIEF.md
# Banked Register File with Indirect Window

This block is the data space of a small 8-bit microcontroller core whose program and data memories are separate. One address space holds the general-purpose RAM and the core's own special registers. The instruction supplies a short direct address. A bank-select register supplies the upper address bits, so the rest of the space can be reached. Five offsets at the bottom of every bank are special registers, and they are mirrored into every bank: an indirect window, the low program-counter byte, the status flags, a pointer, and the bank select.

An access to the indirect window is sent on to the address held in the pointer. The access can step the pointer up or down by one, either before the access or after it. The step wraps at the size of the data space, so the pointer can walk buffers and can serve as a software stack pointer. A write to the program-counter byte produces a jump request that carries the written value. This is how computed jumps are made. The ALU and software share the status register, and the ALU wins when both write it in the same cycle.

Requests arrive on a valid/ready channel. `acc_ready` is always high, so the block never applies back-pressure. A request is taken in any cycle where `acc_valid` is high. Its read data and its jump request are valid combinationally in that same cycle. Its register updates take effect at the following clock edge.

Top module: `banked_regfile`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears the status register, the pointer and the bank select to zero.
- R2: A direct access at an offset from 5 to 31 reaches a general RAM byte at address bank*32+offset. Each of these bytes holds its own value, and a write followed by a read returns the written byte.
- R3: Offsets 1 (program-counter byte), 2 (status), 3 (pointer) and 4 (bank select) are the same registers whichever bank is selected. The pointer reads back zero-extended, and so does the bank select.
- R4: An access at direct offset 0 (the window) in mode 0 acts on the full address held in the pointer. This applies to both reads and writes, and to special registers as well as RAM.
- R5: If the window access resolves to an address whose offset is 0, a read returns 0 and a write changes no register and raises no jump.
- R6: Mode 1 (post-increment) and mode 2 (post-decrement) access the current pointer address and then step the pointer by +1 or -1.
- R7: Mode 3 (pre-increment) and mode 4 (pre-decrement) step the pointer first, then access the new address, and leave the pointer at that address.
- R8: Pointer stepping wraps modulo the size of the data space (127+1 gives 0, and 0-1 gives 127).
- R9: An accepted write that resolves to offset 1 raises `jump_valid` in the same cycle with `jump_target` equal to the write data. A read of offset 1 returns the `pc_low` input and raises no jump.
- R10: A software write to the status register replaces all eight bits. An ALU flag update in the same cycle takes priority. `status_q` presents the register.
- R11: A window write that lands on the pointer register loads the write data into the pointer, and the pointer is not stepped.
- R12: `acc_ready` is always 1. While `acc_valid` is low, no register or RAM changes (except for ALU flag updates), and no jump is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted (always high) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Direct in-bank offset from the instruction |
| acc_mode | input | 3 | Window mode: 0 plain, 1 post-inc, 2 post-dec, 3 pre-inc, 4 pre-dec |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current request |
| pc_low | input | 8 | Current low program-counter byte from the core |
| jump_valid | output | 1 | Jump request from a program-counter byte write |
| jump_target | output | 8 | New low program-counter byte |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 8 | Flag value from the ALU |
| status_q | output | 8 | Current status register |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software status write and an ALU flag update. The bench raises `alu_flag_we` with flags that differ from the written byte, then reads the status back and expects the ALU value. The second pair is a window write that lands on the pointer and the pointer auto-step. The bench aims the pointer at its own register, writes through the window in post-increment mode, and expects the pointer to hold the written data and not the stepped value. Sweeps of every direct offset in every bank, and of every pointer value through the window, are judged against an address model held in the bench.

// File: rtl/brf_pkg.sv
package brf_pkg;

  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4
  } acc_mode_e;

  typedef enum logic [2:0] {
    TGT_NULL,
    TGT_PCL,
    TGT_STATUS,
    TGT_PTR,
    TGT_BANK,
    TGT_RAM
  } tgt_e;

  // In-bank offsets of the mirrored special registers
  localparam int OFS_WIN     = 0;
  localparam int OFS_PCL     = 1;
  localparam int OFS_STATUS  = 2;
  localparam int OFS_PTR     = 3;
  localparam int OFS_BANK    = 4;
  localparam int NUM_SPECIAL = 5;

  function automatic tgt_e decode_ofs(input int ofs);
    case (ofs)
      OFS_WIN:    return TGT_NULL;
      OFS_PCL:    return TGT_PCL;
      OFS_STATUS: return TGT_STATUS;
      OFS_PTR:    return TGT_PTR;
      OFS_BANK:   return TGT_BANK;
      default:    return TGT_RAM;
    endcase
  endfunction

endpackage

// File: rtl/brf_addr_resolve.sv
module brf_addr_resolve
  import brf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DIRECT_W    = 5,
  parameter int BANK_W      = 2,
  parameter int GP_PER_BANK = 27,
  parameter int IDX_W       = 7
) (
  input  logic [BANK_W-1:0]   bank_q,
  input  logic [ADDR_W-1:0]   ptr_q,
  input  logic [DIRECT_W-1:0] acc_addr,
  input  logic [2:0]          acc_mode,
  output logic                is_ind,
  output logic                step_req,
  output logic [ADDR_W-1:0]   ptr_next,
  output tgt_e                tgt,
  output logic [IDX_W-1:0]    ram_idx
);

  logic [ADDR_W-1:0]   direct_addr;
  logic [ADDR_W-1:0]   ind_addr;
  logic [ADDR_W-1:0]   eff_addr;
  logic [ADDR_W-1:0]   ptr_inc;
  logic [ADDR_W-1:0]   ptr_dec;
  logic [DIRECT_W-1:0] eff_ofs;
  int                  idx_calc;

  assign direct_addr = ADDR_W'({bank_q, acc_addr});
  assign ptr_inc     = ptr_q + 1'b1;
  assign ptr_dec     = ptr_q - 1'b1;
  assign is_ind      = (acc_addr == DIRECT_W'(OFS_WIN));

  always_comb begin
    ind_addr = ptr_q;
    ptr_next = ptr_q;
    step_req = 1'b0;
    case (acc_mode)
      AM_POST_INC: begin ptr_next = ptr_inc; step_req = 1'b1; end
      AM_POST_DEC: begin ptr_next = ptr_dec; step_req = 1'b1; end
      AM_PRE_INC:  begin ptr_next = ptr_inc; ind_addr = ptr_inc; step_req = 1'b1; end
      AM_PRE_DEC:  begin ptr_next = ptr_dec; ind_addr = ptr_dec; step_req = 1'b1; end
      default:     ;
    endcase
  end

  assign eff_addr = is_ind ? ind_addr : direct_addr;
  assign eff_ofs  = eff_addr[DIRECT_W-1:0];
  assign tgt      = decode_ofs(int'(eff_ofs));

  always_comb begin
    idx_calc = int'(eff_addr >> DIRECT_W) * GP_PER_BANK + int'(eff_ofs) - NUM_SPECIAL;
    ram_idx  = IDX_W'(idx_calc);
  end

endmodule

// File: rtl/brf_gp_ram.sv
module brf_gp_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 108,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (we && idx == IDX_W'(i)) word_q <= wdata;
    end
    assign words[i] = word_q;
  end

  assign rdata = (int'(idx) < DEPTH) ? words[idx] : '0;

endmodule

// File: rtl/brf_special_regs.sv
module brf_special_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_status,
  input  logic              wr_ptr,
  input  logic              wr_bank,
  input  logic [DATA_W-1:0] wdata,
  input  logic              alu_flag_we,
  input  logic [DATA_W-1:0] alu_flags,
  input  logic              ptr_step,
  input  logic [ADDR_W-1:0] ptr_next,
  output logic [DATA_W-1:0] status_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [BANK_W-1:0] bank_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           status_q <= '0;
    else if (alu_flag_we) status_q <= alu_flags;
    else if (wr_status)   status_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (wr_ptr)   ptr_q <= wdata[ADDR_W-1:0];
    else if (ptr_step) ptr_q <= ptr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (wr_bank) bank_q <= wdata[BANK_W-1:0];
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SPACE_BYTES = 128,
  parameter int DIRECT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic                acc_write,
  input  logic [DIRECT_W-1:0] acc_addr,
  input  logic [2:0]          acc_mode,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   pc_low,
  output logic                jump_valid,
  output logic [DATA_W-1:0]   jump_target,
  input  logic                alu_flag_we,
  input  logic [DATA_W-1:0]   alu_flags,
  output logic [DATA_W-1:0]   status_q
);

  localparam int BANK_BYTES  = 1 << DIRECT_W;
  localparam int NUM_BANKS   = SPACE_BYTES / BANK_BYTES;
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W      = $clog2(SPACE_BYTES);
  localparam int GP_PER_BANK = BANK_BYTES - NUM_SPECIAL;
  localparam int RAM_DEPTH   = NUM_BANKS * GP_PER_BANK;
  localparam int IDX_W       = $clog2(RAM_DEPTH);

  logic              is_ind;
  logic              step_req;
  logic [ADDR_W-1:0] ptr_next;
  tgt_e              tgt;
  logic [IDX_W-1:0]  ram_idx;
  logic [ADDR_W-1:0] ptr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] ram_rdata;
  logic              wr_fire;

  assign acc_ready = 1'b1;
  assign wr_fire   = acc_valid && acc_write;

  brf_addr_resolve #(
    .ADDR_W(ADDR_W), .DIRECT_W(DIRECT_W), .BANK_W(BANK_W),
    .GP_PER_BANK(GP_PER_BANK), .IDX_W(IDX_W)
  ) u_resolve (
    .bank_q(bank_q), .ptr_q(ptr_q), .acc_addr(acc_addr), .acc_mode(acc_mode),
    .is_ind(is_ind), .step_req(step_req), .ptr_next(ptr_next),
    .tgt(tgt), .ram_idx(ram_idx)
  );

  brf_gp_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(wr_fire && tgt == TGT_RAM), .idx(ram_idx),
    .wdata(acc_wdata), .rdata(ram_rdata)
  );

  brf_special_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_sregs (
    .clk(clk), .rst_n(rst_n),
    .wr_status(wr_fire && tgt == TGT_STATUS),
    .wr_ptr(wr_fire && tgt == TGT_PTR),
    .wr_bank(wr_fire && tgt == TGT_BANK),
    .wdata(acc_wdata),
    .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
    .ptr_step(acc_valid && is_ind && step_req), .ptr_next(ptr_next),
    .status_q(status_q), .ptr_q(ptr_q), .bank_q(bank_q)
  );

  always_comb begin
    case (tgt)
      TGT_PCL:    rd_data = pc_low;
      TGT_STATUS: rd_data = status_q;
      TGT_PTR:    rd_data = DATA_W'(ptr_q);
      TGT_BANK:   rd_data = DATA_W'(bank_q);
      TGT_RAM:    rd_data = ram_rdata;
      default:    rd_data = '0;
    endcase
  end

  assign jump_valid  = wr_fire && tgt == TGT_PCL;
  assign jump_target = acc_wdata;

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int BANK_W   = 2,
  parameter int DIRECT_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                acc_write,
  input logic [DIRECT_W-1:0] acc_addr,
  input logic [2:0]          acc_mode,
  input logic [DATA_W-1:0]   acc_wdata,
  input logic [DATA_W-1:0]   rd_data,
  input logic                jump_valid,
  input logic [DATA_W-1:0]   jump_target,
  input logic                alu_flag_we,
  input logic [DATA_W-1:0]   alu_flags,
  input logic [DATA_W-1:0]   status_q,
  input logic [ADDR_W-1:0]   ptr_q,
  input logic [BANK_W-1:0]   bank_q
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && ptr_q == '0 && bank_q == '0));

  p_null_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == '0 && acc_mode == 3'd0 &&
     ptr_q[DIRECT_W-1:0] == '0) |-> rd_data == '0);

  p_post_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == '0 && acc_mode == 3'd1)
    |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

  p_pre_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == '0 && acc_mode == 3'd4)
    |=> ptr_q == ADDR_W'($past(ptr_q) - 1'b1));

  p_jump_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> (acc_valid && acc_write && jump_target == acc_wdata));

  p_alu_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alu_flag_we |=> status_q == $past(alu_flags));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !alu_flag_we)
    |=> ($stable(status_q) && $stable(ptr_q) && $stable(bank_q)));

endmodule

bind banked_regfile brf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DIRECT_W(DIRECT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_mode(acc_mode), .acc_wdata(acc_wdata),
  .rd_data(rd_data), .jump_valid(jump_valid), .jump_target(jump_target),
  .alu_flag_we(alu_flag_we), .alu_flags(alu_flags), .status_q(status_q),
  .ptr_q(ptr_q), .bank_q(bank_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PCL_VAL = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic       acc_write = 1'b0;
  logic [4:0] acc_addr = '0;
  logic [2:0] acc_mode = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic [7:0] pc_low = PCL_VAL;
  logic       jump_valid;
  logic [7:0] jump_target;
  logic       alu_flag_we = 1'b0;
  logic [7:0] alu_flags = '0;
  logic [7:0] status_q;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] got_rd;
  logic       got_jv;
  logic [7:0] got_jt;

  logic [7:0] mem_m [128];
  logic [7:0] status_m = '0;
  logic [6:0] ptr_m    = '0;
  logic [1:0] bank_m   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_mode(acc_mode),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .pc_low(pc_low),
    .jump_valid(jump_valid), .jump_target(jump_target),
    .alu_flag_we(alu_flag_we), .alu_flags(alu_flags), .status_q(status_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic v, input logic w, input logic [4:0] a,
                     input logic [2:0] m, input logic [7:0] d);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_mode = m; acc_wdata = d;
    #1;
    got_rd = rd_data; got_jv = jump_valid; got_jt = jump_target;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_write = 1'b0; alu_flag_we = 1'b0;
  endtask

  function automatic logic [7:0] model_at(input logic [6:0] a);
    case (a[4:0])
      5'd0:    return 8'h00;
      5'd1:    return PCL_VAL;
      5'd2:    return status_m;
      5'd3:    return {1'b0, ptr_m};
      5'd4:    return {6'b0, bank_m};
      default: return mem_m[a];
    endcase
  endfunction

  task automatic set_ptr(input logic [6:0] p);
    acc(1, 1, 5'd3, 3'd0, {1'b0, p});
    ptr_m = p;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R12 ready
    acc(1, 0, 5'd2, 0, 0); chk("R1 status", got_rd, 8'h00);
    acc(1, 0, 5'd3, 0, 0); chk("R1 pointer", got_rd, 8'h00);
    acc(1, 0, 5'd4, 0, 0); chk("R1 bank", got_rd, 8'h00);
    chk("R12 ready", {7'b0, acc_ready}, 8'h01);

    // R2 direct sweep of every general byte in every bank
    for (int b = 0; b < 4; b++) begin
      acc(1, 1, 5'd4, 0, 8'(b)); bank_m = 2'(b);
      for (int o = 5; o < 32; o++) begin
        logic [7:0] v;
        v = 8'((b * 37 + o * 5 + 1) & 255);
        acc(1, 1, 5'(o), 0, v);
        mem_m[b * 32 + o] = v;
      end
    end
    for (int b = 0; b < 4; b++) begin
      acc(1, 1, 5'd4, 0, 8'(b)); bank_m = 2'(b);
      for (int o = 5; o < 32; o++) begin
        acc(1, 0, 5'(o), 0, 0);
        chk("R2 direct readback", got_rd, mem_m[b * 32 + o]);
      end
    end

    // R3 special registers mirrored in every bank
    for (int b = 0; b < 4; b++) begin
      acc(1, 1, 5'd4, 0, 8'(b)); bank_m = 2'(b);
      acc(1, 0, 5'd4, 0, 0); chk("R3 bank readback", got_rd, 8'(b));
      set_ptr(7'(b * 7 + 9));
      acc(1, 1, 5'd4, 0, 8'((b + 1) % 4)); bank_m = 2'((b + 1) % 4);
      acc(1, 0, 5'd3, 0, 0); chk("R3 pointer mirror", got_rd, {1'b0, ptr_m});
    end

    // R4 / R5 window sweep over every pointer value
    acc(1, 1, 5'd2, 0, 8'h33); status_m = 8'h33;
    acc(1, 1, 5'd4, 0, 8'd2); bank_m = 2'd2;
    for (int a = 0; a < 128; a++) begin
      set_ptr(7'(a));
      acc(1, 0, 5'd0, 0, 0);
      chk(((a % 32) == 0) ? "R5 null read" : "R4 window read", got_rd, model_at(7'(a)));
    end

    // R4 window write lands on RAM
    set_ptr(7'h47);
    acc(1, 1, 5'd0, 0, 8'hC3); mem_m[7'h47] = 8'hC3;
    acc(1, 0, 5'd7, 0, 0); chk("R4 window write", got_rd, 8'hC3);

    // R5 write to the window through the window does nothing
    set_ptr(7'h20);
    acc(1, 1, 5'd0, 0, 8'h99); chk("R5 no jump", {7'b0, got_jv}, 8'h00);
    acc(1, 0, 5'd3, 0, 0); chk("R5 pointer kept", got_rd, 8'h20);
    acc(1, 0, 5'd2, 0, 0); chk("R5 status kept", got_rd, 8'h33);
    acc(1, 0, 5'd0, 0, 0); chk("R5 null read after write", got_rd, 8'h00);

    // R6 post-increment / post-decrement
    set_ptr(7'h45);
    for (int k = 0; k < 3; k++) begin
      acc(1, 0, 5'd0, 3'd1, 0);
      chk("R6 post-inc data", got_rd, mem_m[8'h45 + k]);
    end
    acc(1, 0, 5'd3, 0, 0); chk("R6 post-inc pointer", got_rd, 8'h48);
    acc(1, 0, 5'd0, 3'd2, 0); chk("R6 post-dec data", got_rd, mem_m[8'h48]);
    acc(1, 0, 5'd3, 0, 0); chk("R6 post-dec pointer", got_rd, 8'h47);

    // R7 pre-increment / pre-decrement
    acc(1, 0, 5'd0, 3'd3, 0); chk("R7 pre-inc data", got_rd, mem_m[8'h48]);
    acc(1, 0, 5'd3, 0, 0); chk("R7 pre-inc pointer", got_rd, 8'h48);
    acc(1, 0, 5'd0, 3'd4, 0); chk("R7 pre-dec data", got_rd, mem_m[8'h47]);
    acc(1, 0, 5'd3, 0, 0); chk("R7 pre-dec pointer", got_rd, 8'h47);

    // R8 wrap at both ends
    set_ptr(7'h7F);
    acc(1, 0, 5'd0, 3'd1, 0); chk("R8 wrap up data", got_rd, mem_m[8'h7F]);
    acc(1, 0, 5'd3, 0, 0); chk("R8 wrap up pointer", got_rd, 8'h00);
    acc(1, 0, 5'd0, 3'd4, 0); chk("R8 wrap down data", got_rd, mem_m[8'h7F]);
    acc(1, 0, 5'd3, 0, 0); chk("R8 wrap down pointer", got_rd, 8'h7F);

    // R9 computed jump
    acc(1, 1, 5'd1, 0, 8'h84);
    chk("R9 direct jump valid", {7'b0, got_jv}, 8'h01);
    chk("R9 direct jump target", got_jt, 8'h84);
    set_ptr(7'h61);
    acc(1, 1, 5'd0, 0, 8'h17);
    chk("R9 window jump valid", {7'b0, got_jv}, 8'h01);
    chk("R9 window jump target", got_jt, 8'h17);
    acc(1, 0, 5'd1, 0, 0);
    chk("R9 read pc", got_rd, PCL_VAL);
    chk("R9 read no jump", {7'b0, got_jv}, 8'h00);

    // R10 status write and ALU priority
    acc(1, 1, 5'd2, 0, 8'hA5);
    acc(1, 0, 5'd2, 0, 0); chk("R10 status write", got_rd, 8'hA5);
    chk("R10 status port", status_q, 8'hA5);
    @(negedge clk); alu_flag_we = 1'b1; alu_flags = 8'hF0;
    acc(1, 1, 5'd2, 0, 8'h0F);
    acc(1, 0, 5'd2, 0, 0); chk("R10 alu wins", got_rd, 8'hF0);
    @(negedge clk); alu_flag_we = 1'b1; alu_flags = 8'h3C;
    acc(0, 0, 5'd2, 0, 0);
    chk("R10 alu alone", status_q, 8'h3C);

    // R11 window write onto the pointer beats the step
    set_ptr(7'h03);
    acc(1, 1, 5'd0, 3'd1, 8'h50);
    acc(1, 0, 5'd3, 0, 0); chk("R11 pointer loaded", got_rd, 8'h50);

    // R12 idle request is ignored
    acc(1, 1, 5'd4, 0, 8'd1); bank_m = 2'd1;
    acc(0, 1, 5'd10, 0, 8'hEE);
    chk("R12 idle no jump", {7'b0, got_jv}, 8'h00);
    acc(0, 1, 5'd1, 0, 8'h22);
    chk("R12 idle pc write no jump", {7'b0, got_jv}, 8'h00);
    acc(1, 0, 5'd10, 0, 0); chk("R12 idle ram kept", got_rd, mem_m[32 + 10]);
    acc(1, 0, 5'd3, 0, 0); chk("R12 idle pointer kept", got_rd, 8'h50);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule